// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers interrupt requests from several 32-bit source banks and presents them to a processor on two separate request lines. Each source is captured on its rising edge into a sticky pending bit. Software reads the pending bits and acknowledges them by writing ones to a per-bank clear address.

A fixed subset of source positions forms the high tier. Each of these positions carries a priority level from 1 to 15, and several positions may share a level. A per-level mask in the control register decides which levels may raise the high request. A summary register reports the highest level that is both pending and unmasked, so an interrupt handler can dispatch without scanning the banks.

Every other source position belongs to the low tier. The low tier has no priority. It is gated bit by bit through per-bank enable registers and raises its own request line. A global enable in the control register gates both request lines.

Top module: `dual_tier_icu`

## Requirements
- R1: A write to a bank's clear address (word 4*b+1) clears exactly the pending bits written as one. All other pending bits of that bank stay set.
- R2: A rising edge on a source input sets its pending bit, visible in the bank status (word 4*b) after one clock edge. If the edge arrives in the same cycle as a clear of that bit, the bit stays set.
- R3: High-tier positions and their levels are fixed:
  - bank 0: bits 24 and 25 at level 15, bit 30 at 14, bit 29 at 13, bits 0 and 7 at level 1
  - bank 1: bit 31 at 11, bit 21 at 10, bits 16..19 at 9, bits 0..1 at 8
  - bank 2: bits 16..19 at 7, bits 0..1 at 6
  - bank 3: bits 2..3 at 12, bit 5 at 5, bit 18 at 4, bit 17 at 3, bit 27 at 2

  Every other position is low tier.
- R4: Control register (word 4*NUM_BANKS) bits 15:1 are the per-level mask, where bit L unmasks level L. A pending high-tier bit contributes to the high request only when the mask bit of its level is set. With all mask bits clear, the high tier is silent.
- R5: Summary register (word 4*NUM_BANKS+1) holds three fields:
  - bit 31: high tier active, meaning a pending, unmasked high-tier bit exists
  - bit 30: low tier active, meaning an enabled pending low-tier bit exists
  - bits 3:0: the highest pending unmasked level, or 0 when there is none
- R6: Each bank has an enable register (word 4*b+2). Any pending low-tier bit whose enable is set asserts irq_lo. Enable bits at high-tier positions read 0 and are ignored.
- R7: Control register bit 16 is the global enable. When it is clear, irq_hi and irq_lo are both low. The summary flags are not gated by it.
- R8: irq_hi and irq_lo are registered. Each reflects the pending, enable, mask and global state one clock edge after that state changes.
- R9: Status reads return the raw pending bits whatever their enable or mask state.
- R10: After reset, all pending bits, enables, the mask, the global enable and both request lines are 0. Reads of clear addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_BANKS*BANK_W | Raw source levels, bank b in bits [b*BANK_W +: BANK_W] |
| cpu_addr | input | ADDR_W | Register word address |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_wdata | input | BANK_W | Write data |
| cpu_rdata | output | BANK_W | Combinational read data for cpu_addr |
| irq_hi | output | 1 | High-tier request line |
| irq_lo | output | 1 | Low-tier request line |

## Verification
A source edge driven before a clock edge shows in the status and summary reads one edge later. The request lines follow one edge after that, so the bench samples status at the first falling edge after the stimulus and the request lines at the second. At the first sample it also confirms that both request lines are still low. Register writes take effect at the edge that accepts them, so reads right after the write see the new state while the request lines are compared one edge later. A sweep pulses every one of the 128 source positions in turn and compares tier, vector and request lines against a level table the bench fills in by itself.

// File: rtl/dti_pkg.sv
package dti_pkg;

  localparam int LVL_N = 16;
  localparam int VEC_W = $clog2(LVL_N);

  // Fixed level of a source position; 0 means the position is low tier.
  function automatic logic [3:0] src_level(input int bank, input int bitpos);
    logic [3:0] l;
    l = 4'd0;
    case (bank)
      0: case (bitpos)
           24, 25: l = 4'd15;
           30:     l = 4'd14;
           29:     l = 4'd13;
           0, 7:   l = 4'd1;
           default: l = 4'd0;
         endcase
      1: case (bitpos)
           31:             l = 4'd11;
           21:             l = 4'd10;
           16, 17, 18, 19: l = 4'd9;
           0, 1:           l = 4'd8;
           default:        l = 4'd0;
         endcase
      2: case (bitpos)
           16, 17, 18, 19: l = 4'd7;
           0, 1:           l = 4'd6;
           default:        l = 4'd0;
         endcase
      3: case (bitpos)
           2, 3:    l = 4'd12;
           5:       l = 4'd5;
           18:      l = 4'd4;
           17:      l = 4'd3;
           27:      l = 4'd2;
           default: l = 4'd0;
         endcase
      default: l = 4'd0;
    endcase
    return l;
  endfunction

  // Index of the highest set bit above bit 0, or 0 when none is set.
  function automatic logic [VEC_W-1:0] top_level(input logic [LVL_N-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = 1; i < LVL_N; i++) begin
      if (v[i]) r = VEC_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/dti_src_bank.sv
module dti_src_bank
  import dti_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int BANK_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] src,
  input  logic [BANK_W-1:0] clr_bits,
  input  logic              en_we,
  input  logic [BANK_W-1:0] en_data,
  output logic [BANK_W-1:0] status,
  output logic [BANK_W-1:0] enable,
  output logic              lo_pend,
  output logic [LVL_N-1:0]  lvl_pend
);

  function automatic logic [BANK_W-1:0] hi_bits();
    logic [BANK_W-1:0] r;
    r = '0;
    for (int i = 0; i < BANK_W; i++) r[i] = (src_level(BANK_IDX, i) != 4'd0);
    return r;
  endfunction

  function automatic logic [BANK_W-1:0] bits_at(input int lvl);
    logic [BANK_W-1:0] r;
    r = '0;
    for (int i = 0; i < BANK_W; i++) r[i] = (int'(src_level(BANK_IDX, i)) == lvl);
    return r;
  endfunction

  localparam logic [BANK_W-1:0] HI_MASK = hi_bits();

  logic [BANK_W-1:0] src_q;
  logic [BANK_W-1:0] rise;

  assign rise = src & ~src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      status <= '0;
      enable <= '0;
    end else begin
      src_q  <= src;
      status <= (status & ~clr_bits) | rise;
      if (en_we) enable <= en_data & ~HI_MASK;
    end
  end

  assign lo_pend = |(status & enable);

  assign lvl_pend[0] = 1'b0;
  for (genvar L = 1; L < LVL_N; L++) begin : g_lvl
    localparam logic [BANK_W-1:0] SEL = bits_at(L);
    assign lvl_pend[L] = |(status & SEL);
  end

endmodule

// File: rtl/dti_prio_enc.sv
module dti_prio_enc
  import dti_pkg::*;
(
  input  logic [LVL_N-1:0] pend,
  input  logic [LVL_N-1:0] mask,
  output logic [LVL_N-1:0] en_lvl,
  output logic             any,
  output logic [VEC_W-1:0] vec
);

  assign en_lvl = pend & mask & {{(LVL_N-1){1'b1}}, 1'b0};
  assign any    = |en_lvl;
  assign vec    = top_level(en_lvl);

endmodule

// File: rtl/dual_tier_icu.sv
module dual_tier_icu
  import dti_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = $clog2(4 * NUM_BANKS + 2)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_in,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic                        cpu_wr,
  input  logic [BANK_W-1:0]           cpu_wdata,
  output logic [BANK_W-1:0]           cpu_rdata,
  output logic                        irq_hi,
  output logic                        irq_lo
);

  localparam int NBITS = NUM_BANKS * BANK_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4 * NUM_BANKS);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(4 * NUM_BANKS + 1);

  // Named internal events, observed by the bound checker.
  logic [NBITS-1:0] status_flat;
  logic [NBITS-1:0] enable_flat;
  logic [NBITS-1:0] clr_flat;
  logic [LVL_N-1:0] mask_lvl;
  logic             glb_en;
  logic [LVL_N-1:0] lvl_all;
  logic [LVL_N-1:0] hi_en_lvl;
  logic             hi_any;
  logic             lo_any;
  logic [VEC_W-1:0] vec;

  logic [LVL_N-1:0] lvl_b [NUM_BANKS];
  logic [NUM_BANKS-1:0] lo_b;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(4 * b + 1);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(4 * b + 2);

    assign clr_flat[b*BANK_W +: BANK_W] =
      (cpu_wr && cpu_addr == A_CLR) ? cpu_wdata : '0;

    dti_src_bank #(
      .BANK_IDX(b),
      .BANK_W  (BANK_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_in[b*BANK_W +: BANK_W]),
      .clr_bits(clr_flat[b*BANK_W +: BANK_W]),
      .en_we   (cpu_wr && cpu_addr == A_EN),
      .en_data (cpu_wdata),
      .status  (status_flat[b*BANK_W +: BANK_W]),
      .enable  (enable_flat[b*BANK_W +: BANK_W]),
      .lo_pend (lo_b[b]),
      .lvl_pend(lvl_b[b])
    );
  end

  always_comb begin
    lvl_all = '0;
    for (int b = 0; b < NUM_BANKS; b++) lvl_all = lvl_all | lvl_b[b];
  end

  assign lo_any = |lo_b;

  dti_prio_enc u_enc (
    .pend  (lvl_all),
    .mask  (mask_lvl),
    .en_lvl(hi_en_lvl),
    .any   (hi_any),
    .vec   (vec)
  );

  // Control register: level mask and global enable.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_lvl <= '0;
      glb_en   <= 1'b0;
    end else if (cpu_wr && cpu_addr == A_CTRL) begin
      mask_lvl <= {cpu_wdata[LVL_N-1:1], 1'b0};
      glb_en   <= cpu_wdata[LVL_N];
    end
  end

  // Registered request lines.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_hi <= 1'b0;
      irq_lo <= 1'b0;
    end else begin
      irq_hi <= glb_en && hi_any;
      irq_lo <= glb_en && lo_any;
    end
  end

  // Read mux.
  always_comb begin
    cpu_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (cpu_addr == ADDR_W'(4 * b))     cpu_rdata = status_flat[b*BANK_W +: BANK_W];
      if (cpu_addr == ADDR_W'(4 * b + 2)) cpu_rdata = enable_flat[b*BANK_W +: BANK_W];
    end
    if (cpu_addr == A_CTRL) begin
      cpu_rdata[LVL_N-1:0] = mask_lvl;
      cpu_rdata[LVL_N]     = glb_en;
    end
    if (cpu_addr == A_SUM) begin
      cpu_rdata[BANK_W-1]  = hi_any;
      cpu_rdata[BANK_W-2]  = lo_any;
      cpu_rdata[VEC_W-1:0] = vec;
    end
  end

endmodule

// File: rtl/dti_chk.sv
module dti_chk
  import dti_pkg::*;
#(
  parameter int NBITS = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBITS-1:0] src_in,
  input logic [NBITS-1:0] status_flat,
  input logic [NBITS-1:0] clr_flat,
  input logic [LVL_N-1:0] mask_lvl,
  input logic [LVL_N-1:0] hi_en_lvl,
  input logic             glb_en,
  input logic             hi_any,
  input logic             lo_any,
  input logic [VEC_W-1:0] vec,
  input logic             irq_hi,
  input logic             irq_lo
);

  // R1: pending bits not cleared stay set
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_flat & $past(status_flat & ~clr_flat)) == $past(status_flat & ~clr_flat)));

  // R2: a rising edge always lands in status, clear or not
  a_r2_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |->
      ((status_flat & ($past(src_in) & ~$past(src_in, 2))) == ($past(src_in) & ~$past(src_in, 2))));

  // R4: no masked level takes part in the high tier
  a_r4_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en_lvl & ~mask_lvl) == '0);

  // R5: vector is zero when nothing high is active
  a_r5_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_any |-> (vec == '0));

  // R5: vector names an active level
  a_r5_vec_active: assert property (@(posedge clk) disable iff (!rst_n)
    hi_any |-> hi_en_lvl[vec]);

  // R7: global enable off silences both lines one edge later
  a_r7_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (!irq_hi && !irq_lo));

  // R8: high line follows with one edge of latency
  a_r8_hi_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && hi_any) |=> irq_hi);

  a_r8_hi_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_any |=> !irq_hi);

  // R6: low line follows enabled pending low-tier bits
  a_r6_lo_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && lo_any) |=> irq_lo);

  a_r6_lo_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_any |=> !irq_lo);

endmodule

bind dual_tier_icu dti_chk #(.NBITS(NUM_BANKS * BANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_in     (src_in),
  .status_flat(status_flat),
  .clr_flat   (clr_flat),
  .mask_lvl   (mask_lvl),
  .hi_en_lvl  (hi_en_lvl),
  .glb_en     (glb_en),
  .hi_any     (hi_any),
  .lo_any     (lo_any),
  .vec        (vec),
  .irq_hi     (irq_hi),
  .irq_lo     (irq_lo)
);

// File: tb/dual_tier_icu_tb.sv
module dual_tier_icu_tb;

  localparam int NB = 4;
  localparam int BW = 32;
  localparam int AW = 5;
  localparam int A_CTRL = 4 * NB;
  localparam int A_SUM  = 4 * NB + 1;
  localparam logic [31:0] CTRL_ALL = 32'h0001_FFFE;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NB*BW-1:0] src_in = '0;
  logic [AW-1:0]    cpu_addr = '0;
  logic             cpu_wr = 1'b0;
  logic [BW-1:0]    cpu_wdata = '0;
  logic [BW-1:0]    cpu_rdata;
  logic             irq_hi, irq_lo;

  int checks = 0;
  int errors = 0;
  int lvl_tab [NB][BW];

  always #10 clk = ~clk;

  dual_tier_icu #(.NUM_BANKS(NB), .BANK_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    cpu_addr = AW'(a);
    #1;
    d = cpu_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cpu_addr = AW'(a); cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  task automatic pulse(input int b, input int i);
    src_in[b*BW + i] = 1'b1;
    @(negedge clk);
    src_in[b*BW + i] = 1'b0;
  endtask

  task automatic fill_table();
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < BW; i++) lvl_tab[b][i] = 0;
    lvl_tab[3][27] = 2;  lvl_tab[3][17] = 3;  lvl_tab[3][18] = 4;  lvl_tab[3][5] = 5;
    lvl_tab[3][2] = 12;  lvl_tab[3][3] = 12;
    lvl_tab[0][0] = 1;   lvl_tab[0][7] = 1;   lvl_tab[0][29] = 13;
    lvl_tab[0][30] = 14; lvl_tab[0][24] = 15; lvl_tab[0][25] = 15;
    lvl_tab[2][0] = 6;   lvl_tab[2][1] = 6;
    for (int i = 16; i < 20; i++) begin
      lvl_tab[2][i] = 7;
      lvl_tab[1][i] = 9;
    end
    lvl_tab[1][0] = 8;   lvl_tab[1][1] = 8;
    lvl_tab[1][21] = 10; lvl_tab[1][31] = 11;
  endtask

  function automatic logic [31:0] summary(input logic hi, input logic lo, input int v);
    return {hi, lo, 26'd0, 4'(v)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    logic [31:0] hmask;
    fill_table();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 irq_hi", 32'(irq_hi), 0);
    check("R10 irq_lo", 32'(irq_lo), 0);
    for (int b = 0; b < NB; b++) begin
      rd(4*b, d);     check("R10 status", d, 0);
      rd(4*b + 2, d); check("R10 enable", d, 0);
    end
    rd(A_CTRL, d); check("R10 control", d, 0);
    rd(A_SUM, d);  check("R10 summary", d, 0);

    // Setup: everything enabled
    wr(A_CTRL, CTRL_ALL);
    rd(A_CTRL, d); check("R4 control readback", d, CTRL_ALL);
    for (int b = 0; b < NB; b++) begin
      wr(4*b + 2, 32'hFFFF_FFFF);
      hmask = '0;
      for (int i = 0; i < BW; i++) if (lvl_tab[b][i] != 0) hmask[i] = 1'b1;
      rd(4*b + 2, d); check("R6 high positions read 0 in enable", d, ~hmask);
    end

    // Sweep every source position (R2, R3, R5, R6, R8)
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < BW; i++) begin
        int l;
        l = lvl_tab[b][i];
        pulse(b, i);
        rd(4*b, d);  check("R2 edge captured", d, 32'h1 << i);
        check("R8 hi not yet", 32'(irq_hi), 0);
        check("R8 lo not yet", 32'(irq_lo), 0);
        rd(A_SUM, d); check("R3 R5 summary", d, summary(l != 0, l == 0, l));
        @(negedge clk);
        check("R3 irq_hi", 32'(irq_hi), 32'(l != 0));
        check("R6 irq_lo", 32'(irq_lo), 32'(l == 0));
        wr(4*b + 1, 32'h1 << i);
        rd(4*b, d); check("R1 cleared", d, 0);
        @(negedge clk);
        check("R8 hi drop", 32'(irq_hi), 0);
        check("R8 lo drop", 32'(irq_lo), 0);
      end
    end

    // R1: clear only written bits; R10 clear address reads 0
    src_in[1*BW + 3] = 1'b1; src_in[1*BW + 9] = 1'b1;
    @(negedge clk);
    src_in = '0;
    wr(4*1 + 1, 32'h0000_0008);
    rd(4*1, d);     check("R1 partial clear", d, 32'h0000_0200);
    rd(4*1 + 1, d); check("R10 clear addr reads 0", d, 0);
    wr(4*1 + 1, 32'h0000_0200);

    // R2: edge coincident with clear of the same bit
    src_in[2*BW + 10] = 1'b1;
    cpu_addr = AW'(4*2 + 1); cpu_wdata = 32'h0000_0400; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; src_in = '0;
    rd(4*2, d); check("R2 edge beats clear", d, 32'h0000_0400);
    wr(4*2 + 1, 32'h0000_0400);

    // R5, R4: priority among levels 15, 13, 2
    pulse(0, 29); pulse(3, 27); pulse(0, 24);
    rd(A_SUM, d); check("R5 highest is 15", d, summary(1, 0, 15));
    wr(A_CTRL, CTRL_ALL & ~32'h8000);
    rd(A_SUM, d); check("R4 level 15 masked gives 13", d, summary(1, 0, 13));
    @(negedge clk);
    check("R4 irq_hi with 13", 32'(irq_hi), 1);
    wr(A_CTRL, 32'h0001_0000);
    rd(A_SUM, d); check("R4 all masked summary", d, summary(0, 0, 0));
    rd(0, d); check("R9 masked still pending", d, 32'h2100_0000);
    @(negedge clk);
    check("R4 all masked irq_hi", 32'(irq_hi), 0);
    wr(A_CTRL, CTRL_ALL);
    wr(1, 32'h2100_0000); wr(4*3 + 1, 32'h0800_0000);
    rd(A_SUM, d); check("R1 all high cleared", d, 0);

    // R7: global enable off with a pending low bit
    pulse(3, 0);
    wr(A_CTRL, 32'h0000_FFFE);
    rd(A_SUM, d); check("R7 summary ungated", d, summary(0, 1, 0));
    @(negedge clk);
    check("R7 irq_lo gated", 32'(irq_lo), 0);
    wr(A_CTRL, CTRL_ALL);
    @(negedge clk);
    check("R7 irq_lo back", 32'(irq_lo), 1);
    wr(4*3 + 1, 32'h1);

    // R9: disabled low bit still reads pending, no request
    wr(4*2 + 2, 32'hFFFF_FBFF);
    pulse(2, 10);
    rd(4*2, d);   check("R9 raw pending", d, 32'h0000_0400);
    rd(A_SUM, d); check("R9 summary low idle", d, 0);
    @(negedge clk);
    check("R9 irq_lo idle", 32'(irq_lo), 0);
    wr(4*2 + 2, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R6 enable late raises irq_lo", 32'(irq_lo), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule